// File: doc/BRIEF.md
# Codec Control-Port Boot Sequencer

After reset, this block programs an audio codec's control registers over a four-wire serial link. It needs no processor. A single `start` pulse launches a fixed script that has two phases:

- **Powerdown preamble.** A short run of frames that puts the converters into powerdown.
- **Main configuration list.** After a long settling pause, a longer list runs. It writes every control and volume register and then reads back the peak-level and ADC control registers.

Each word the codec returns during the main list is kept in a small buffer. After `done`, the buffer can be read through a simple address/data port.

The block generates the serial clock, an active-low frame strobe that doubles as chip select, and the outgoing data line. All of it runs on the system clock. Enable strobes from a divider pace the logic, so there is no derived clock domain.

- The frame strobe uses late timing: it drops in the same bit period as the first data bit.
- Outgoing data is launched while the serial clock is low.
- Incoming data is sampled as the serial clock rises.
- Between frames, the link rests with the strobe high and the clock low.

Top module: `codec_cfg_seq`

## Requirements
- R1: Every command word is 16 bits and is shifted out most significant bit first. The fields are:
  - bits 15..12: register address
  - bit 11: direction (1 = read, 0 = write)
  - bit 10: always 0
  - bits 9..0: register data
- R2: `fs_n` falls in the same bit period as the first data bit and stays low for exactly 16 serial clock periods (32*HALF_DIV system clocks). It rises together with the final falling clock edge.
- R3: `sclk` rests low. During a frame, each high phase and each low phase lasts exactly HALF_DIV system clocks, so f_sclk = f_clk/(2*HALF_DIV).
- R4: `mosi` changes only while `sclk` is low and holds steady for every high phase. `miso` is captured on each rising `sclk` edge.
- R5: The preamble is four words, in this order: 0x0004, 0x0004, 0xC080, 0xC080.
- R6: The gap from the end of the last preamble frame (rise of `fs_n`) to the start of the first main frame (fall of `fs_n`) is at least SETTLE_CYCLES system clocks. It exceeds that by no more than a few bit periods.
- R7: The main list is 21 words, in this order:
  - 0x0000, 0x0000, 0x1000
  - 0x23FF, 0x33FF, 0x43FF, 0x53FF, 0x63FF, 0x73FF
  - 0xC000, 0xC000, 0xE000
  - 0xD380, 0xD380
  - 0x8800, 0x9800, 0xA800, 0xB800, 0xC800, 0xD800, 0xE800
- R8: After `done`, `rd_data` at address i (0..20) equals the 16-bit word received on `miso` during main frame i, first received bit in bit 15. Words received during the preamble are not stored.
- R9: Between frames, `fs_n` stays high and `sclk` stays low for at least IDLE_BITS full bit periods (2*IDLE_BITS*HALF_DIV system clocks).
- R10: Start, busy and done behave as follows:
  - A start pulse while idle or done raises `busy` on the next cycle and clears `done`.
  - A start pulse while busy has no effect on the frame sequence.
  - `busy` falls only when `done` rises.
  - `done` holds until the next start.
- R11: In and after reset, before any start: `sclk`=0, `fs_n`=1, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the script |
| busy | output | 1 | Script in progress |
| done | output | 1 | Script finished; held until next start |
| sclk | output | 1 | Serial bit clock, idle low |
| fs_n | output | 1 | Active-low frame strobe / chip select |
| mosi | output | 1 | Serial command data to codec |
| miso | input | 1 | Serial response data from codec |
| rd_addr | input | 5 | Readback buffer index |
| rd_data | output | 16 | Readback buffer word |

## Verification
The checker watches four things on every cycle:
- The serial link rests correctly: the clock is only high inside a frame, and the strobe never rises with the clock high.
- `mosi` stays frozen through every clock-high phase.
- `busy` and `done` are mutually exclusive.
- `busy` only ends by completing the script.

Only the bench scenarios can show the rest: the exact command words and their order, the 16-bit frame length, the divider-derived half periods, the length of the settling pause, that the readback buffer matches random codec responses, and that a mid-run start pulse leaves the script untouched.

// File: rtl/codec_cfg_pkg.sv
`timescale 1ns/1ps
package codec_cfg_pkg;

   localparam int CMD_W    = 16;
   localparam int NUM_PRE  = 4;
   localparam int NUM_MAIN = 21;
   localparam int IDX_W    = $clog2(NUM_MAIN + 1);

   typedef logic [CMD_W-1:0] cmd_word_t;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PRE,
      S_SETTLE,
      S_MAIN,
      S_DONE
   } seq_state_t;

   // Pack address, direction and data into one command word; bit 10 stays 0.
   function automatic cmd_word_t pack_cmd(input logic [3:0] addr,
                                          input logic       rd,
                                          input logic [9:0] data);
      return {addr, rd, 1'b0, data};
   endfunction

   // Command script: phase selects preamble (0) or main list (1).
   function automatic cmd_word_t script_word(input logic main_ph,
                                             input logic [IDX_W-1:0] idx);
      cmd_word_t w;
      w = '0;
      if (!main_ph) begin
         w = (idx < IDX_W'(2)) ? pack_cmd(4'h0, 1'b0, 10'h004)
                               : pack_cmd(4'hC, 1'b0, 10'h080);
      end else begin
         case (idx)
            5'd0, 5'd1:  w = pack_cmd(4'h0, 1'b0, 10'h000);
            5'd2:        w = pack_cmd(4'h1, 1'b0, 10'h000);
            5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8:
                         w = pack_cmd(4'(idx - 5'd1), 1'b0, 10'h3FF);
            5'd9, 5'd10: w = pack_cmd(4'hC, 1'b0, 10'h000);
            5'd11:       w = pack_cmd(4'hE, 1'b0, 10'h000);
            5'd12, 5'd13: w = pack_cmd(4'hD, 1'b0, 10'h380);
            5'd14, 5'd15, 5'd16, 5'd17, 5'd18, 5'd19, 5'd20:
                         w = pack_cmd(4'(idx - 5'd6), 1'b1, 10'h000);
            default:     w = '0;
         endcase
      end
      return w;
   endfunction

endpackage

// File: rtl/cfg_tick_gen.sv
`timescale 1ns/1ps
module cfg_tick_gen #(
   parameter int unsigned HALF_DIV = 15
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   generate
      if (HALF_DIV == 1) begin : g_every
         always_ff @(posedge clk) begin
            if (rst) tick <= 1'b0;
            else     tick <= 1'b1;
         end
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt  <= '0;
               tick <= 1'b0;
            end else if (cnt == CW'(HALF_DIV - 1)) begin
               cnt  <= '0;
               tick <= 1'b1;
            end else begin
               cnt  <= cnt + CW'(1);
               tick <= 1'b0;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cfg_frame_engine.sv
`timescale 1ns/1ps
module cfg_frame_engine #(
   parameter int WORD_W    = 16,
   parameter int IDLE_BITS = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              go,
   input  logic [WORD_W-1:0] tx_word,
   output logic              ready,
   output logic              frame_done,
   output logic [WORD_W-1:0] rx_word,
   output logic              sclk,
   output logic              fs_n,
   output logic              mosi,
   input  logic              miso
);

   localparam int HALF_N = 2 * WORD_W;
   localparam int HW     = $clog2(HALF_N + 1);
   localparam int GAP_N  = 2 * IDLE_BITS;
   localparam int GW     = $clog2(GAP_N + 1);

   typedef enum logic [1:0] {E_IDLE, E_PEND, E_SHIFT, E_GAP} eng_state_t;

   eng_state_t        st;
   logic [HW-1:0]     half;
   logic [GW-1:0]     gap_cnt;
   logic [WORD_W-1:0] tx_sr;
   logic [WORD_W-1:0] rx_sr;

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= E_IDLE;
         half       <= '0;
         gap_cnt    <= '0;
         tx_sr      <= '0;
         rx_sr      <= '0;
         sclk       <= 1'b0;
         fs_n       <= 1'b1;
         mosi       <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         case (st)
            E_IDLE: if (go) begin
               tx_sr <= tx_word;
               st    <= E_PEND;
            end
            E_PEND: if (tick) begin
               fs_n  <= 1'b0;
               sclk  <= 1'b0;
               mosi  <= tx_sr[WORD_W-1];
               tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
               half  <= '0;
               st    <= E_SHIFT;
            end
            E_SHIFT: if (tick) begin
               if (half == HW'(HALF_N - 1)) begin
                  fs_n       <= 1'b1;
                  sclk       <= 1'b0;
                  mosi       <= 1'b0;
                  frame_done <= 1'b1;
                  gap_cnt    <= '0;
                  st         <= E_GAP;
               end else if (!half[0]) begin
                  sclk  <= 1'b1;
                  rx_sr <= {rx_sr[WORD_W-2:0], miso};
                  half  <= half + HW'(1);
               end else begin
                  sclk  <= 1'b0;
                  mosi  <= tx_sr[WORD_W-1];
                  tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
                  half  <= half + HW'(1);
               end
            end
            E_GAP: if (tick) begin
               if (gap_cnt == GW'(GAP_N - 1)) st <= E_IDLE;
               else gap_cnt <= gap_cnt + GW'(1);
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   assign ready   = (st == E_IDLE);
   assign rx_word = rx_sr;

endmodule

// File: rtl/cfg_readback_buf.sv
`timescale 1ns/1ps
module cfg_readback_buf #(
   parameter int DEPTH   = 21,
   parameter int WIDTH   = 16,
   parameter int AW      = 5,
   parameter bit REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [WIDTH-1:0] rd_comb;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && (waddr < AW'(DEPTH))) begin
         mem[waddr] <= wdata;
      end
   end

   always_comb rd_comb = (raddr < AW'(DEPTH)) ? mem[raddr] : '0;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) rdata <= '0;
            else     rdata <= rd_comb;
         end
      end else begin : g_comb
         assign rdata = rd_comb;
      end
   endgenerate

endmodule

// File: rtl/codec_cfg_seq.sv
`timescale 1ns/1ps
module codec_cfg_seq import codec_cfg_pkg::*; #(
   parameter int unsigned HALF_DIV      = 15,
   parameter int unsigned SETTLE_CYCLES = 30_000_000,
   parameter int unsigned IDLE_BITS     = 1,
   parameter bit          RD_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              fs_n,
   output logic              mosi,
   input  logic              miso,
   input  logic [IDX_W-1:0]  rd_addr,
   output logic [CMD_W-1:0]  rd_data
);

   localparam int SW = $clog2(SETTLE_CYCLES + 1);

   generate
      if (HALF_DIV < 1)      begin : g_bad_div    $error("HALF_DIV must be >= 1");      end
      if (SETTLE_CYCLES < 1) begin : g_bad_settle $error("SETTLE_CYCLES must be >= 1"); end
      if (IDLE_BITS < 1)     begin : g_bad_idle   $error("IDLE_BITS must be >= 1");     end
   endgenerate

   seq_state_t       st;
   logic [IDX_W-1:0] idx;
   logic [SW-1:0]    settle_cnt;
   logic             inflight;
   logic             tick;
   logic             frm_go, frm_ready, frm_done;
   cmd_word_t        frm_rx, frm_tx;
   logic             sending;

   cfg_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk(clk), .rst(rst), .tick(tick)
   );

   cfg_frame_engine #(.WORD_W(CMD_W), .IDLE_BITS(int'(IDLE_BITS))) u_eng (
      .clk(clk), .rst(rst), .tick(tick), .go(frm_go), .tx_word(frm_tx),
      .ready(frm_ready), .frame_done(frm_done), .rx_word(frm_rx),
      .sclk(sclk), .fs_n(fs_n), .mosi(mosi), .miso(miso)
   );

   cfg_readback_buf #(.DEPTH(NUM_MAIN), .WIDTH(CMD_W), .AW(IDX_W),
                      .REG_OUT(RD_REGISTERED)) u_buf (
      .clk(clk), .rst(rst), .we(frm_done && (st == S_MAIN)), .waddr(idx),
      .wdata(frm_rx), .raddr(rd_addr), .rdata(rd_data)
   );

   assign sending = (st == S_PRE) || (st == S_MAIN);
   assign frm_go  = sending && frm_ready && !inflight;
   assign frm_tx  = script_word(st == S_MAIN, idx);

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= S_IDLE;
         idx        <= '0;
         settle_cnt <= '0;
         inflight   <= 1'b0;
      end else begin
         case (st)
            S_IDLE, S_DONE: if (start) begin
               st       <= S_PRE;
               idx      <= '0;
               inflight <= 1'b0;
            end
            S_PRE, S_MAIN: begin
               if (frm_done) begin
                  inflight <= 1'b0;
                  if (st == S_PRE && idx == IDX_W'(NUM_PRE - 1)) begin
                     st         <= S_SETTLE;
                     idx        <= '0;
                     settle_cnt <= '0;
                  end else if (st == S_MAIN && idx == IDX_W'(NUM_MAIN - 1)) begin
                     st <= S_DONE;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end else if (frm_go) begin
                  inflight <= 1'b1;
               end
            end
            S_SETTLE: begin
               if (settle_cnt == SW'(SETTLE_CYCLES - 1)) st <= S_MAIN;
               else settle_cnt <= settle_cnt + SW'(1);
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy = (st == S_PRE) || (st == S_SETTLE) || (st == S_MAIN);
   assign done = (st == S_DONE);

endmodule

// File: rtl/codec_cfg_seq_chk.sv
`timescale 1ns/1ps
module codec_cfg_seq_chk (
   input logic clk,
   input logic rst,
   input logic start,
   input logic busy,
   input logic done,
   input logic sclk,
   input logic fs_n,
   input logic mosi
);

   // R9 / R3: clock only toggles inside a frame
   p_sclk_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
      sclk |-> !fs_n);

   // R2: strobe releases together with the final falling clock edge
   p_fs_release_low_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(fs_n) |-> !sclk);

   // R4: data frozen through each high phase
   p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
      sclk |-> $stable(mosi));

   // R10: busy and done never together
   p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));

   // R10: busy only ends by completion
   p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done);

   // R10: done held until a new start
   p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done);

   // R10: accepted start raises busy next cycle
   p_start_accept_r10: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);

   // R11: link at rest whenever not busy
   p_rest_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (fs_n && !sclk));

endmodule

bind codec_cfg_seq codec_cfg_seq_chk u_chk (
   .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
   .sclk(sclk), .fs_n(fs_n), .mosi(mosi)
);

// File: tb/codec_cfg_seq_test.sv
`timescale 1ns/1ps
module codec_cfg_seq_test;

   localparam int HD     = 2;
   localparam int SETTLE = 60;
   localparam int IDLEB  = 1;
   localparam int NFRM   = 25;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        miso = 1'b0;
   logic [4:0]  rd_addr = '0;
   logic        busy, done, sclk, fs_n, mosi;
   logic [15:0] rd_data;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   codec_cfg_seq #(.HALF_DIV(HD), .SETTLE_CYCLES(SETTLE), .IDLE_BITS(IDLEB)) uut (
      .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
      .sclk(sclk), .fs_n(fs_n), .mosi(mosi), .miso(miso),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always #2.5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input int a, input int rd, input int d);
      return 16'((a << 12) | (rd << 11) | d);
   endfunction

   function automatic logic [15:0] exp_word(input int n);
      int m;
      if (n < 2) return mk(0, 0, 'h004);
      if (n < 4) return mk('hC, 0, 'h080);
      m = n - 4;
      if (m < 2)  return mk(0, 0, 0);
      if (m == 2) return mk(1, 0, 0);
      if (m < 9)  return mk(m - 1, 0, 'h3FF);
      if (m < 11) return mk('hC, 0, 0);
      if (m == 11) return mk('hE, 0, 0);
      if (m < 14) return mk('hD, 0, 'h380);
      return mk(m - 6, 1, 0);
   endfunction

   // link monitor and codec responder
   logic [15:0] rsp [NFRM];
   logic [15:0] resp, word;
   int frm_cnt = 0, bits = 0, rbit = 0;
   int cyc = 0, fall_cyc = 0, rise_cyc = 0, hi_len = 0, lo_len = 0;
   int bad_per = 0, bad_mosi = 0, bad_idle = 0;
   logic prev_s = 1'b0, prev_f = 1'b1, prev_m = 1'b0;

   always @(negedge clk) begin
      if (!rst) begin
         cyc++;
         if (prev_f && !fs_n) begin
            if (frm_cnt == 4)
               check((cyc - rise_cyc) >= SETTLE && (cyc - rise_cyc) <= SETTLE + 4*HD*(IDLEB+1) + 8,
                     "R6 settle gap", cyc - rise_cyc, SETTLE);
            else if (frm_cnt > 0)
               check((cyc - rise_cyc) >= 2*IDLEB*HD, "R9 idle gap", cyc - rise_cyc, 2*IDLEB*HD);
            fall_cyc = cyc; bits = 0; word = '0; lo_len = 0;
            resp = (frm_cnt < NFRM) ? rsp[frm_cnt] : 16'h0;
            miso = resp[15]; rbit = 14;
         end
         if (sclk) hi_len++;
         if (!sclk && !fs_n) lo_len++;
         if (!prev_s && sclk) begin
            if (fs_n) bad_idle++;
            else begin
               word = {word[14:0], mosi}; bits++;
               if (lo_len != HD) bad_per++;
               lo_len = 0;
            end
         end
         if (prev_s && sclk && (mosi !== prev_m)) bad_mosi++;
         if (prev_s && !sclk) begin
            if (hi_len != HD) bad_per++;
            hi_len = 0;
            if (!fs_n && rbit >= 0) begin miso = resp[rbit]; rbit--; end
         end
         if (!prev_f && fs_n) begin
            check(bits == 16, "R2 bits per frame", bits, 16);
            check((cyc - fall_cyc) == 32*HD, "R2 strobe low time", cyc - fall_cyc, 32*HD);
            check(word[10] == 1'b0, "R1 reserved bit", word, word & 16'hFBFF);
            if (frm_cnt < 4) check(word == exp_word(frm_cnt), "R5 preamble word", word, exp_word(frm_cnt));
            else             check(word == exp_word(frm_cnt), "R7 main word R1", word, exp_word(frm_cnt));
            rise_cyc = cyc; frm_cnt++;
         end
         prev_s = sclk; prev_f = fs_n; prev_m = mosi;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic run_script(input bit from_done);
      int waited;
      for (int i = 0; i < NFRM; i++) rsp[i] = 16'($urandom);
      rsp[4] = 16'hFFFF;  // corner: all ones
      rsp[5] = 16'h0000;  // corner: all zeros
      frm_cnt = 0; bad_per = 0; bad_mosi = 0; bad_idle = 0;
      pulse_start();
      check(busy == 1'b1 && done == 1'b0, from_done ? "R10 restart from done" : "R10 start accept",
            {busy, done}, 2);
      repeat (200 + ($urandom % 1200)) @(negedge clk);
      pulse_start();  // ignored: script must still produce exactly NFRM correct frames
      waited = 0;
      while (!done && waited < 20000) begin @(negedge clk); waited++; end
      check(done == 1'b1, "R10 done reached", done, 1);
      check(frm_cnt == NFRM, "R10 start ignored while busy", frm_cnt, NFRM);
      check(bad_per == 0, "R3 half period", bad_per, 0);
      check(bad_mosi == 0, "R4 mosi stable high", bad_mosi, 0);
      check(bad_idle == 0, "R9 clock idle between frames", bad_idle, 0);
      repeat (20 + ($urandom % 40)) @(negedge clk);
      check(done && !busy && fs_n && !sclk && frm_cnt == NFRM, "R10 done held",
            {done, busy, fs_n, sclk}, 4'b1010);
      for (int i = 0; i < 21; i++) begin
         rd_addr = 5'(i);
         #1;
         check(rd_data == rsp[4 + i], "R8 readback", rd_data, rsp[4 + i]);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      check(sclk == 0 && fs_n == 1 && busy == 0 && done == 0, "R11 during reset",
            {sclk, fs_n, busy, done}, 4'b0100);
      rst = 1'b0;
      repeat (30) @(negedge clk);
      check(sclk == 0 && fs_n == 1 && busy == 0 && done == 0, "R11 after reset",
            {sclk, fs_n, busy, done}, 4'b0100);
      run_script(1'b0);
      run_script(1'b1);
      finish_run();
   end

endmodule